// File: doc/BRIEF.md
# Measurement Gate Pulse Generator

This block turns a free-running reference-clock count into a periodic measurement gate. Each gate period has a high phase of a fixed number of reference cycles followed by a low phase. The low phase fills out the rest of the requested period. Both phase boundaries are produced by one compare register. On every match the register advances by the length of the phase that has just started, and the gate output flips. The counter and the compare sum both wrap modulo 2^CNT_W, so a match is a plain equality test.

Software or a small front end clamps the requested gate time and converts it to cycles. It then presents the full period and the high-phase length, and pulses a load strobe. The values are held in a staging register and a pending indication is raised. They take effect only at the next high-to-low transition of the gate, and only after that transition's low interval has already been scheduled with the old value. No period in flight is ever cut short or stretched. Out of reset the gate is high and the first fall is scheduled at the reset counter value plus the default high count.

Top module: `gate_pulse_gen`

## Requirements
- R1: During reset and right after it, gate_o is 1 and pend_o is 0. The first high phase lasts exactly DEF_HIGH cycles, counted from the reset counter value of 0.
- R2: Each high phase lasts exactly the active high count in clock cycles.
- R3: Each low phase lasts exactly the active period minus the active high count.
- R4: One cycle after load_i is sampled high, pend_o is 1. While pend_o is 1 and no gate fall occurs, the gate timing in use does not change.
- R5: pend_o returns to 0 only in the same cycle that gate_o falls. Staged values are adopted only at such a fall.
- R6: The low phase that begins at the adopting fall still uses the previous low count. The following high and low phases use the new values.
- R7: A second load while a value is pending replaces the staged value. Only the last one loaded is ever adopted.
- R8: A load sampled in the same cycle as a gate fall is staged and stays pending. Any value that was already pending is adopted at that fall, and the newly loaded value is adopted at the next fall.
- R9: Gate edges occur exactly when the wrapped counter equals the compare value. Phase lengths stay exact across counter wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle strobe that stages new timing |
| period_i | input | CNT_W | Full gate period in cycles (must exceed high_i) |
| high_i | input | CNT_W | High-phase length in cycles (at least 1) |
| gate_o | output | 1 | Measurement gate level |
| pend_o | output | 1 | Staged timing not yet adopted |

## Verification
The assertions watch four things on every cycle. The gate moves only when the counter reaches the compare value. After each rise the compare value sits exactly one high count ahead, and after each fall exactly one old low count ahead. Active timing and the pending flag change only at a gate fall. What the bench scenarios alone can show is the externally visible phase lengths: the first phase after reset, one old low phase and then new timing after each load, and the overwrite and same-cycle load-at-fall orderings. They also show that every phase keeps its length over hundreds of cycles crossing the counter wrap.

// File: rtl/gpg_pkg.sv
package gpg_pkg;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } gate_lvl_e;

endpackage

// File: rtl/gpg_refcount.sv
module gpg_refcount #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o      = st_q.cnt;
    assign cnt_next_o = st_d.cnt;

endmodule

// File: rtl/gpg_stager.sv
module gpg_stager #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic             adopt_i,
    output logic [CNT_W-1:0] stg_high_o,
    output logic [CNT_W-1:0] stg_low_o,
    output logic             pend_o
);

    typedef struct packed {
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] low;
        logic             pend;
    } stg_st_t;

    stg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adopt_i) begin
            st_d.pend = 1'b0;
        end
        if (load_i) begin
            st_d.high = high_i;
            st_d.low  = period_i - high_i;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stg_high_o = st_q.high;
    assign stg_low_o  = st_q.low;
    assign pend_o     = st_q.pend;

    AST_LOAD_RAISES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> st_q.pend); // R4

    AST_ADOPT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        adopt_i |-> st_q.pend); // R5

    AST_IDLE_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adopt_i) |=> $stable(st_q)); // R7

endmodule

// File: rtl/gpg_toggle.sv
module gpg_toggle
    import gpg_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter int unsigned DEF_HIGH   = 4000000,
    parameter int unsigned DEF_PERIOD = 100000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [CNT_W-1:0] stg_high_i,
    input  logic [CNT_W-1:0] stg_low_i,
    input  logic             pend_i,
    output logic             gate_o,
    output logic             adopt_o
);

    localparam int unsigned      DEF_LOW = DEF_PERIOD - DEF_HIGH;
    localparam logic [CNT_W-1:0] DEF_H   = DEF_HIGH[CNT_W-1:0];
    localparam logic [CNT_W-1:0] DEF_L   = DEF_LOW[CNT_W-1:0];

    typedef struct packed {
        gate_lvl_e        gate;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] low;
    } tgl_st_t;

    tgl_st_t st_d, st_q;
    logic    match;
    logic    fall;

    always_comb begin
        st_d    = st_q;
        match   = (cnt_next_i == st_q.cmp);
        fall    = match && (st_q.gate == LVL_HIGH);
        adopt_o = fall && pend_i;
        if (match) begin
            if (st_q.gate == LVL_HIGH) begin
                st_d.gate = LVL_LOW;
                st_d.cmp  = st_q.cmp + st_q.low;
            end else begin
                st_d.gate = LVL_HIGH;
                st_d.cmp  = st_q.cmp + st_q.high;
            end
        end
        if (adopt_o) begin
            st_d.high = stg_high_i;
            st_d.low  = stg_low_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gate <= LVL_HIGH;
            st_q.cmp  <= DEF_H;
            st_q.high <= DEF_H;
            st_q.low  <= DEF_L;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;

    AST_RISE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.gate) |-> ((st_q.cmp - cnt_i) == st_q.high)); // R2

    AST_FALL_OLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.gate) |-> ((st_q.cmp - cnt_i) == $past(st_q.low))); // R6

    AST_EDGE_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gate != $past(st_q.gate)) |-> (cnt_i == $past(st_q.cmp))); // R9

    AST_TIMING_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.high != $past(st_q.high)) || (st_q.low != $past(st_q.low)))
            |-> $fell(st_q.gate)); // R5

endmodule

// File: rtl/gate_pulse_gen.sv
module gate_pulse_gen #(
    parameter int          CNT_W      = 32,
    parameter int unsigned DEF_HIGH   = 4000000,
    parameter int unsigned DEF_PERIOD = 100000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] high_i,
    output logic             gate_o,
    output logic             pend_o
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] stg_high;
    logic [CNT_W-1:0] stg_low;
    logic             adopt;

    gpg_refcount #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_o      (cnt),
        .cnt_next_o (cnt_next)
    );

    gpg_stager #(
        .CNT_W (CNT_W)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .period_i   (period_i),
        .high_i     (high_i),
        .adopt_i    (adopt),
        .stg_high_o (stg_high),
        .stg_low_o  (stg_low),
        .pend_o     (pend_o)
    );

    gpg_toggle #(
        .CNT_W      (CNT_W),
        .DEF_HIGH   (DEF_HIGH),
        .DEF_PERIOD (DEF_PERIOD)
    ) u_toggle (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt),
        .cnt_next_i (cnt_next),
        .stg_high_i (stg_high),
        .stg_low_i  (stg_low),
        .pend_i     (pend_o),
        .gate_o     (gate_o),
        .adopt_o    (adopt)
    );

    AST_PEND_DROPS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_o) |-> $fell(gate_o)); // R5

    AST_LOAD_AT_FALL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> pend_o); // R8

endmodule

// File: tb/gate_pulse_gen_test.sv
module gate_pulse_gen_test;

    localparam int W  = 8;
    localparam int DH = 3;
    localparam int DP = 8;
    localparam int NV = 5;
    localparam logic [2*W-1:0] VEC [NV] = '{
        {8'd8,  8'd3},
        {8'd5,  8'd1},
        {8'd20, 8'd7},
        {8'd2,  8'd1},
        {8'd40, 8'd30}
    };

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         load  = 1'b0;
    logic [W-1:0] per   = '0;
    logic [W-1:0] hi    = '0;
    logic         gate;
    logic         pend;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    int  cur_h;
    int  cur_l;
    int  n;

    always #4 clk = ~clk;

    gate_pulse_gen #(
        .CNT_W      (W),
        .DEF_HIGH   (DH),
        .DEF_PERIOD (DP)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .period_i (per),
        .high_i   (hi),
        .gate_o   (gate),
        .pend_o   (pend)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // count negedges while gate stays at lvl
    task automatic run_len(input logic lvl, output int len);
        len = 0;
        while (gate == lvl) begin
            @(negedge clk);
            len++;
        end
    endtask

    task automatic load_one(input int p, input int h);
        per  = W'(p);
        hi   = W'(h);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset state, R1
        repeat (3) @(negedge clk);
        chk(gate == 1'b1, "R1 gate in reset", int'(gate), 1);
        chk(pend == 1'b0, "R1 pend in reset", int'(pend), 0);
        rst_n = 1'b1;
        run_len(1'b1, n);
        chk(n == DH, "R1 first high length", n, DH);
        chk(pend == 1'b0, "R1 no pending after reset", int'(pend), 0);
        cur_h = DH;
        cur_l = DP - DH;

        // vector walk: load at each fall, then trace the phases
        for (int i = 0; i < NV; i++) begin
            int vp;
            int vh;
            vp = int'(VEC[i][2*W-1:W]);
            vh = int'(VEC[i][W-1:0]);
            load_one(vp, vh);
            chk(pend == 1'b1, "R4 pend after load", int'(pend), 1);
            run_len(1'b0, n);
            chk(n + 1 == cur_l, "R3 low length", n + 1, cur_l);
            run_len(1'b1, n);
            chk(n == cur_h, "R4 high unchanged while pending", n, cur_h);
            chk(pend == 1'b0, "R5 pend clears at fall", int'(pend), 0);
            run_len(1'b0, n);
            chk(n == cur_l, "R6 adopting fall keeps old low", n, cur_l);
            run_len(1'b1, n);
            chk(n == vh, "R2 new high length", n, vh);
            cur_h = vh;
            cur_l = vp - vh;
        end
        run_len(1'b0, n);
        chk(n == cur_l, "R3 final low length", n, cur_l);

        // R7: second load overwrites pending value
        run_len(1'b1, n);
        load_one(12, 4);
        load_one(9, 6);
        chk(pend == 1'b1, "R7 pend after two loads", int'(pend), 1);
        run_len(1'b0, n);
        chk(n + 2 == cur_l, "R7 low untouched", n + 2, cur_l);
        run_len(1'b1, n);
        chk(n == cur_h, "R7 old high", n, cur_h);
        run_len(1'b0, n);
        chk(n == cur_l, "R7 old low at adoption", n, cur_l);
        run_len(1'b1, n);
        chk(n == 6, "R7 last loaded high wins", n, 6);
        cur_h = 6;
        cur_l = 3;

        // R8: load coinciding with a fall
        load_one(10, 5);
        run_len(1'b0, n);
        repeat (cur_h - 1) @(negedge clk);
        chk(gate == 1'b1, "R8 still high before fall", int'(gate), 1);
        load_one(7, 2);
        chk(gate == 1'b0, "R8 fall with load", int'(gate), 0);
        chk(pend == 1'b1, "R8 new value stays pending", int'(pend), 1);
        run_len(1'b0, n);
        chk(n == cur_l, "R8 old low", n, cur_l);
        run_len(1'b1, n);
        chk(n == 5, "R8 earlier value adopted first", n, 5);
        chk(pend == 1'b0, "R8 later value adopted next fall", int'(pend), 0);
        run_len(1'b0, n);
        chk(n == 5, "R8 earlier low", n, 5);
        run_len(1'b1, n);
        chk(n == 2, "R8 later high", n, 2);
        run_len(1'b0, n);
        chk(n == 5, "R8 later low", n, 5);

        // R9: long run across counter wrap
        run_len(1'b1, n);
        load_one(37, 11);
        run_len(1'b0, n);
        run_len(1'b1, n);
        run_len(1'b0, n);
        for (int k = 0; k < 8; k++) begin
            run_len(1'b1, n);
            chk(n == 11, "R9 high across wrap", n, 11);
            run_len(1'b0, n);
            chk(n == 26, "R9 low across wrap", n, 26);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule